// File: doc/BRIEF.md
# Bottleneck Call Dispatcher with Per-Large-Core Request Queues

This block decides where a bottleneck call runs on an asymmetric multi-core chip. Every small core holds its own acceleration table, which maps a bottleneck ID to the number of a large core. When a small core issues a call, its table is looked up by ID. On a miss, the core is told in the next cycle to run the code itself. On a hit, a request is queued at the named large core. The request holds the ID, the target PC, the stack pointer and the number of the calling core. The calling core then stalls until its request completes.

Each large core owns one request queue. The queue has one slot per small core and hands out requests oldest first. The large core claims the request at the head with a take strobe. Later it reports a return with the bottleneck ID. The matching claimed request then leaves the queue, and a completion pulse goes back to the core that sent it. An external selector fills and trims the tables. It installs an ID only when the waiting-cycle count it supplies is above a threshold, and it can remove an ID. The interconnect is modelled as direct wires.

Top module: `bneck_dispatch`

## Requirements
- R1: A call from a core that is not stalled, whose ID is absent from that core's table, raises `run_local` for that core for exactly one cycle, starting the cycle after the call. It creates no request and does not raise `stall`.
- R2: A call whose ID is present queues a request at the large core stored for that ID. From the next cycle, `stall` for the caller is high and the request is visible at that large core's head outputs: ID, PC, SP, and the caller number as a binary index.
- R3: `stall` stays high until the completion for that core arrives. Calls from a stalled core are ignored: no `run_local`, and no new request.
- R4: A `ret_valid` at a large core, whose `ret_id` matches a claimed request in that queue, removes that request. In the next cycle it raises `done` for the requesting core for one cycle and drops that core's `stall` in the same cycle. A return that matches no claimed request does nothing.
- R5: The head of a queue is its oldest unclaimed request. Requests arriving in the same cycle are ordered by ascending core number. `req_take` claims the head, and the next head appears one cycle later.
- R6: An install takes effect only when `sel_twc` is strictly greater than `THRESH`. Otherwise the table is unchanged.
- R7: When a table is full, an install of a new ID replaces the entry installed least recently. Reinstalling an ID that is already present makes it the most recent entry and updates its large-core number.
- R8: Removing an ID that is absent changes nothing. Removing an ID that is present makes later calls with it run locally. If install and remove are both asserted in the same cycle, only the install is applied.
- R9: A lookup in the same cycle as an install of the same ID sees the table as it was before the install.
- R10: A queue holds one request from every small core at once, and none is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| call_valid | input | NS | Per-core call strobe |
| call_id | input | NS*IDW | Per-core bottleneck ID |
| call_pc | input | NS*AW | Per-core target PC |
| call_sp | input | NS*AW | Per-core stack pointer |
| run_local | output | NS | Per-core pulse: execute locally |
| stall | output | NS | Per-core wait for remote completion |
| done | output | NS | Per-core completion pulse |
| sel_install | input | 1 | Selector install command |
| sel_remove | input | 1 | Selector remove command |
| sel_core | input | CW | Small core whose table is addressed |
| sel_id | input | IDW | ID to install or remove |
| sel_large | input | LW | Large core assigned on install |
| sel_twc | input | TWW | Waiting-cycle count behind the install |
| req_valid | output | NL | Per-large-core head valid |
| req_id | output | NL*IDW | Head ID |
| req_pc | output | NL*AW | Head target PC |
| req_sp | output | NL*AW | Head stack pointer |
| req_core | output | NL*CW | Head requester number |
| req_take | input | NL | Claim the head request |
| ret_valid | input | NL | Return strobe from a large core |
| ret_id | input | NL*IDW | ID being returned |

## Verification
Every result is due one clock edge after its stimulus. This covers `run_local`, `stall` and a new head for a call; a new head after a take; `done` and the fall of `stall` after a return; and a table change after an install or remove. The bench drives inputs one time unit after a rising edge and reads outputs one time unit after the following edge. One cycle later it checks that each pulse has ended. The effects of a table update are checked through the very next call. In the same-cycle case, the call is driven on the same edge as the install, so the call must still miss.

// File: rtl/bneck_dispatch.sv
module bneck_dispatch #(
  parameter int NS     = 4,
  parameter int NL     = 2,
  parameter int ENT    = 32,
  parameter int IDW    = 8,
  parameter int AW     = 32,
  parameter int TWW    = 16,
  parameter int THRESH = 100,
  localparam int CW = (NS > 1) ? $clog2(NS) : 1,
  localparam int LW = (NL > 1) ? $clog2(NL) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NS-1:0]    call_valid,
  input  logic [NS*IDW-1:0] call_id,
  input  logic [NS*AW-1:0] call_pc,
  input  logic [NS*AW-1:0] call_sp,
  output logic [NS-1:0]    run_local,
  output logic [NS-1:0]    stall,
  output logic [NS-1:0]    done,
  input  logic             sel_install,
  input  logic             sel_remove,
  input  logic [CW-1:0]    sel_core,
  input  logic [IDW-1:0]   sel_id,
  input  logic [LW-1:0]    sel_large,
  input  logic [TWW-1:0]   sel_twc,
  output logic [NL-1:0]    req_valid,
  output logic [NL*IDW-1:0] req_id,
  output logic [NL*AW-1:0] req_pc,
  output logic [NL*AW-1:0] req_sp,
  output logic [NL*CW-1:0] req_core,
  input  logic [NL-1:0]    req_take,
  input  logic [NL-1:0]    ret_valid,
  input  logic [NL*IDW-1:0] ret_id
);
  localparam int EW = (ENT > 1) ? $clog2(ENT) : 1;

  logic           tv   [NS][ENT];
  logic [IDW-1:0] tid  [NS][ENT];
  logic [LW-1:0]  tlg  [NS][ENT];
  logic [EW-1:0]  tage [NS][ENT];

  logic [NS-1:0] stall_q, run_q, done_q, done_n, hit, send, miss;
  logic [LW-1:0] hlg [NS];

  always_comb begin
    for (int c = 0; c < NS; c++) begin
      hit[c] = 1'b0;
      hlg[c] = '0;
      for (int e = 0; e < ENT; e++)
        if (tv[c][e] && tid[c][e] == call_id[c*IDW +: IDW]) begin
          hit[c] = 1'b1;
          hlg[c] = tlg[c][e];
        end
    end
  end

  assign send = call_valid & ~stall_q & hit;
  assign miss = call_valid & ~stall_q & ~hit;

  logic          im, ifr, do_ins, do_rem;
  logic [EW-1:0] imi, ifi, ivi, slot, lim;

  always_comb begin
    im = 1'b0; ifr = 1'b0; imi = '0; ifi = '0; ivi = '0;
    for (int e = ENT-1; e >= 0; e--) begin
      if (tv[sel_core][e] && tid[sel_core][e] == sel_id) begin
        im = 1'b1; imi = EW'(e);
      end
      if (!tv[sel_core][e]) begin
        ifr = 1'b1; ifi = EW'(e);
      end
      if (tv[sel_core][e] && tage[sel_core][e] == EW'(ENT-1)) ivi = EW'(e);
    end
  end

  assign slot   = im ? imi : (ifr ? ifi : ivi);
  assign lim    = tage[sel_core][imi];
  assign do_ins = sel_install && (sel_twc > TWW'(THRESH));
  assign do_rem = sel_remove && !do_ins && im;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NS; c++)
        for (int e = 0; e < ENT; e++) tv[c][e] <= 1'b0;
    end else begin
      for (int c = 0; c < NS; c++)
        for (int e = 0; e < ENT; e++)
          if (CW'(c) == sel_core) begin
            if (do_ins) begin
              if (EW'(e) == slot) begin
                tv[c][e]   <= 1'b1;
                tid[c][e]  <= sel_id;
                tlg[c][e]  <= sel_large;
                tage[c][e] <= '0;
              end else if (tv[c][e] && (!im || tage[c][e] < lim)) begin
                tage[c][e] <= tage[c][e] + EW'(1);
              end
            end else if (do_rem) begin
              if (EW'(e) == imi) tv[c][e] <= 1'b0;
              else if (tv[c][e] && tage[c][e] > lim) tage[c][e] <= tage[c][e] - EW'(1);
            end
          end
    end
  end

  logic           qv   [NL][NS], nqv  [NL][NS];
  logic           qs   [NL][NS], nqs  [NL][NS];
  logic [IDW-1:0] qid  [NL][NS], nqid [NL][NS];
  logic [AW-1:0]  qpc  [NL][NS], nqpc [NL][NS];
  logic [AW-1:0]  qsp  [NL][NS], nqsp [NL][NS];
  logic [CW-1:0]  qcr  [NL][NS], nqcr [NL][NS];
  logic [NL-1:0]  hv;
  logic [CW-1:0]  hix [NL];

  always_comb begin
    logic rf;
    int   ridx, cnt;
    done_n = '0;
    for (int l = 0; l < NL; l++) begin
      hv[l] = 1'b0; hix[l] = '0; rf = 1'b0; ridx = 0; cnt = 0;
      for (int i = 0; i < NS; i++) begin
        nqv[l][i] = qv[l][i];   nqs[l][i] = qs[l][i];   nqid[l][i] = qid[l][i];
        nqpc[l][i] = qpc[l][i]; nqsp[l][i] = qsp[l][i]; nqcr[l][i] = qcr[l][i];
      end
      for (int i = NS-1; i >= 0; i--) begin
        if (qv[l][i] && !qs[l][i]) begin
          hv[l] = 1'b1; hix[l] = CW'(i);
        end
        if (ret_valid[l] && qv[l][i] && qs[l][i] && qid[l][i] == ret_id[l*IDW +: IDW]) begin
          rf = 1'b1; ridx = i;
        end
      end
      if (req_take[l] && hv[l]) nqs[l][hix[l]] = 1'b1;
      if (rf) begin
        done_n[qcr[l][ridx]] = 1'b1;
        for (int i = 0; i < NS-1; i++)
          if (i >= ridx) begin
            nqv[l][i] = nqv[l][i+1];   nqs[l][i] = nqs[l][i+1];   nqid[l][i] = nqid[l][i+1];
            nqpc[l][i] = nqpc[l][i+1]; nqsp[l][i] = nqsp[l][i+1]; nqcr[l][i] = nqcr[l][i+1];
          end
        nqv[l][NS-1] = 1'b0;
      end
      for (int i = 0; i < NS; i++) if (nqv[l][i]) cnt++;
      for (int c = 0; c < NS; c++)
        if (send[c] && hlg[c] == LW'(l) && cnt < NS) begin
          nqv[l][cnt]  = 1'b1;
          nqs[l][cnt]  = 1'b0;
          nqid[l][cnt] = call_id[c*IDW +: IDW];
          nqpc[l][cnt] = call_pc[c*AW +: AW];
          nqsp[l][cnt] = call_sp[c*AW +: AW];
          nqcr[l][cnt] = CW'(c);
          cnt++;
        end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < NL; l++)
        for (int i = 0; i < NS; i++) begin
          qv[l][i] <= 1'b0;
          qs[l][i] <= 1'b0;
        end
      stall_q <= '0;
      run_q   <= '0;
      done_q  <= '0;
    end else begin
      qv  <= nqv;  qs  <= nqs;  qid <= nqid;
      qpc <= nqpc; qsp <= nqsp; qcr <= nqcr;
      stall_q <= (stall_q & ~done_n) | send;
      run_q   <= miss;
      done_q  <= done_n;
    end
  end

  for (genvar l = 0; l < NL; l++) begin : g_head
    assign req_id[l*IDW +: IDW] = qid[l][hix[l]];
    assign req_pc[l*AW +: AW]   = qpc[l][hix[l]];
    assign req_sp[l*AW +: AW]   = qsp[l][hix[l]];
    assign req_core[l*CW +: CW] = qcr[l][hix[l]];
  end

  assign req_valid = hv;
  assign stall     = stall_q;
  assign run_local = run_q;
  assign done      = done_q;
endmodule

// File: rtl/bneck_dispatch_chk.sv
module bneck_dispatch_chk #(
  parameter int NS  = 4,
  parameter int NL  = 2,
  parameter int IDW = 8,
  localparam int CW = (NS > 1) ? $clog2(NS) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NS-1:0]     call_valid,
  input logic [NS-1:0]     run_local,
  input logic [NS-1:0]     stall,
  input logic [NS-1:0]     done,
  input logic [NL-1:0]     req_valid,
  input logic [NL-1:0]     req_take,
  input logic [NL*CW-1:0]  req_core,
  input logic [NL*IDW-1:0] req_id
);
  for (genvar c = 0; c < NS; c++) begin : g_core
    a_r1_local_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
      run_local[c] |-> !stall[c]);
    a_r1_local_cause: assert property (@(posedge clk) disable iff (!rst_n)
      run_local[c] |-> $past(call_valid[c] && !stall[c]));
    a_r2_stall_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stall[c]) |-> $past(call_valid[c]));
    a_r3_stall_until_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stall[c]) |-> done[c]);
    a_r4_done_ends_wait: assert property (@(posedge clk) disable iff (!rst_n)
      done[c] |-> (!stall[c] && $past(stall[c])));
  end

  for (genvar l = 0; l < NL; l++) begin : g_large
    a_r5_head_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[l] && !req_take[l]) |=>
        (req_valid[l] && $stable(req_core[l*CW +: CW]) && $stable(req_id[l*IDW +: IDW])));
  end
endmodule

bind bneck_dispatch bneck_dispatch_chk #(.NS(NS), .NL(NL), .IDW(IDW)) u_chk (.*);

// File: tb/sim_bneck_dispatch.sv
`timescale 1ns/1ps
module sim_bneck_dispatch;
  localparam int NS = 4, NL = 2, ENT = 4, IDW = 6, AW = 12, TWW = 8, TH = 20;
  localparam int CW = 2, LW = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS-1:0] call_valid = '0;
  logic [NS*IDW-1:0] call_id = '0;
  logic [NS*AW-1:0] call_pc = '0, call_sp = '0;
  logic [NS-1:0] run_local, stall, done;
  logic sel_install = 1'b0, sel_remove = 1'b0;
  logic [CW-1:0] sel_core = '0;
  logic [IDW-1:0] sel_id = '0;
  logic [LW-1:0] sel_large = '0;
  logic [TWW-1:0] sel_twc = '0;
  logic [NL-1:0] req_valid;
  logic [NL*IDW-1:0] req_id;
  logic [NL*AW-1:0] req_pc, req_sp;
  logic [NL*CW-1:0] req_core;
  logic [NL-1:0] req_take = '0, ret_valid = '0;
  logic [NL*IDW-1:0] ret_id = '0;

  int nchk = 0, nerr = 0;

  always #2 clk = ~clk;

  bneck_dispatch #(.NS(NS), .NL(NL), .ENT(ENT), .IDW(IDW), .AW(AW), .TWW(TWW), .THRESH(TH)) u0 (.*);

  function automatic logic [AW-1:0] pc_of(int id); return AW'(12'h100 + id * 3); endfunction
  function automatic logic [AW-1:0] sp_of(int id); return AW'(12'h800 + id); endfunction

  task automatic cyc; @(posedge clk); #1; endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_call(int c, int id);
    call_valid[c] = 1'b1;
    call_id[c*IDW +: IDW] = IDW'(id);
    call_pc[c*AW +: AW] = pc_of(id);
    call_sp[c*AW +: AW] = sp_of(id);
  endtask

  task automatic call1(int c, int id);
    set_call(c, id); cyc; call_valid = '0;
  endtask

  task automatic install(int c, int id, int l, int twc);
    sel_install = 1'b1; sel_core = CW'(c); sel_id = IDW'(id); sel_large = LW'(l); sel_twc = TWW'(twc);
    cyc; sel_install = 1'b0;
  endtask

  task automatic remove(int c, int id);
    sel_remove = 1'b1; sel_core = CW'(c); sel_id = IDW'(id);
    cyc; sel_remove = 1'b0;
  endtask

  task automatic head(input string tag, int l, int c, int id);
    chk({tag, " valid"}, req_valid[l], 1);
    chk({tag, " core"}, req_core[l*CW +: CW], c);
    chk({tag, " id"}, req_id[l*IDW +: IDW], id);
    chk({tag, " pc"}, req_pc[l*AW +: AW], pc_of(id));
    chk({tag, " sp"}, req_sp[l*AW +: AW], sp_of(id));
  endtask

  task automatic ret1(int l, int id);
    ret_valid[l] = 1'b1; ret_id[l*IDW +: IDW] = IDW'(id); cyc; ret_valid = '0;
  endtask

  task automatic serve(int l, int id, int c);
    req_take[l] = 1'b1; cyc; req_take = '0;
    ret1(l, id);
    chk("R4 done", done, 1 << c);
    chk("R4 stall drop", stall[c], 0);
    cyc;
    chk("R4 done pulse", done, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cyc;
    chk("R2 reset stall", stall, 0);
    chk("R5 reset req_valid", req_valid, 0);
    chk("R4 reset done", done, 0);
    chk("R1 reset run_local", run_local, 0);

    for (int c = 0; c < NS; c++) begin
      call1(c, 1 + c);
      chk("R1 local", run_local, 1 << c);
      chk("R1 no request", req_valid, 0);
      chk("R1 no stall", stall, 0);
      cyc;
      chk("R1 pulse end", run_local, 0);
    end

    install(0, 5, 1, TH);
    call1(0, 5);
    chk("R6 at threshold ignored", run_local, 1);
    cyc;
    install(0, 5, 1, TH + 1);
    call1(0, 5);
    chk("R6 above threshold hit", run_local, 0);
    chk("R2 stall", stall, 1);
    head("R2 head", 1, 0, 5);
    serve(1, 5, 0);

    for (int c = 0; c < NS; c++)
      for (int l = 0; l < NL; l++) begin
        automatic int id = 8 + 2 * c + l;
        install(c, id, l, TH + 5);
        call1(c, id);
        chk("R2 stall sweep", stall, 1 << c);
        chk("R2 target sweep", req_valid, 1 << l);
        head("R2 sweep", l, c, id);
        serve(l, id, c);
      end

    install(3, 40, 0, 30);
    install(3, 41, 0, 30);
    install(3, 42, 0, 30);
    call1(3, 14);
    chk("R7 oldest evicted", run_local, 4'b1000);
    cyc;
    call1(3, 15);
    chk("R7 second kept", stall, 4'b1000);
    serve(1, 15, 3);
    install(3, 15, 1, 30);
    install(3, 43, 0, 30);
    call1(3, 40);
    chk("R7 refresh evicts next", run_local, 4'b1000);
    cyc;
    call1(3, 15);
    chk("R7 refreshed kept", stall, 4'b1000);
    serve(1, 15, 3);

    remove(3, 33);
    call1(3, 41);
    chk("R8 absent remove no effect", stall, 4'b1000);
    serve(0, 41, 3);
    remove(3, 41);
    call1(3, 41);
    chk("R8 removed runs local", run_local, 4'b1000);
    chk("R8 removed no stall", stall, 0);
    cyc;

    sel_install = 1'b1; sel_core = 2; sel_id = 50; sel_large = 0; sel_twc = 30;
    set_call(2, 50);
    cyc;
    sel_install = 1'b0; call_valid = '0;
    chk("R9 same cycle sees old", run_local, 4'b0100);
    chk("R9 no stall", stall, 0);
    call1(2, 50);
    chk("R9 next call hits", stall, 4'b0100);
    serve(0, 50, 2);

    install(3, 60, 0, 30);
    set_call(2, 12); set_call(0, 8);
    cyc; call_valid = '0;
    head("R5 first", 0, 0, 8);
    chk("R5 stall pair", stall, 4'b0101);
    set_call(3, 60); set_call(1, 10);
    cyc; call_valid = '0;
    head("R5 still oldest", 0, 0, 8);
    chk("R10 all stalled", stall, 4'b1111);
    call1(1, 1);
    chk("R3 ignored local", run_local, 0);
    chk("R3 stall held", stall, 4'b1111);
    head("R3 queue unchanged", 0, 0, 8);
    req_take[0] = 1'b1;
    cyc; head("R5 order 2", 0, 2, 12);
    cyc; head("R5 order 3", 0, 1, 10);
    cyc; head("R10 fourth kept", 0, 3, 60);
    cyc; chk("R10 all claimed", req_valid, 0);
    req_take = '0;

    ret1(0, 33);
    chk("R4 unmatched ignored", done, 0);
    chk("R4 unmatched stall", stall, 4'b1111);
    ret1(0, 60);
    chk("R4 out of order", done, 4'b1000);
    ret1(0, 8);
    chk("R4 core0", done, 4'b0001);
    ret1(0, 12);
    chk("R4 core2", done, 4'b0100);
    ret1(0, 10);
    chk("R4 core1", done, 4'b0010);
    chk("R4 all clear", stall, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule